// File: doc/BRIEF.md
# SPI-Programmed Chip-Select Demultiplexer

This block lets a controller with few select lines address many peripherals. It listens as an SPI receiver in mode 0 (clock idles low, data sampled on the rising clock edge, most-significant bit first) on a dedicated control select. A complete frame loads a small index register. A second select input, the routed select, then reaches exactly one of `NUM_OUT` active-low device selects, the one the index names. All other device selects stay high, so the peripherals behind them ignore the shared bus.

The SPI clock, data and both select inputs are brought into the system clock domain through synchronizer chains, and all frame decoding runs on the system clock. The routed select itself reaches the outputs through pure gating, so a device sees its select with no clock delay. While the control select is low, the block returns the currently stored index on MISO so the controller can confirm the setting. The index never changes while the routed select is active. A load attempted then is held and applied once the routed select returns high.

Top module: `csx_expander`

## Requirements
- R1: After synchronous reset every `dev_sel_n` bit is 1, `spi_miso_en` is 0 and `spi_miso` is 0.
- R2: Until a valid frame has loaded an index, `dev_sel_n` stays all ones even while `route_sel_n` is low.
- R3: A frame of exactly IDX_W bits (IDX_W = ceil(log2(NUM_OUT)), 3 for the default of 6) is shifted in MSB first on rising `spi_sck` while `ctl_sel_n` is low, and is committed when `ctl_sel_n` rises. After that, `route_sel_n` low drives only `dev_sel_n[index]` low.
- R4: A frame with fewer or more than IDX_W rising clock edges leaves the stored index unchanged.
- R5: A stored index equal to or above NUM_OUT keeps every `dev_sel_n` bit high.
- R6: `dev_sel_n[index]` follows `route_sel_n` combinationally, with no clock edge between input and output.
- R7: A frame that completes while `route_sel_n` is low does not change the routing until `route_sel_n` has gone high. The held value is then applied, and the next low on `route_sel_n` uses it.
- R8: Activity on `spi_sck` and `spi_mosi` while `ctl_sel_n` is high does not alter the stored index.
- R9: While `ctl_sel_n` is low, `spi_miso_en` is 1 and `spi_miso` presents the index stored at frame start, MSB first. The first bit is valid before the first rising clock edge, the following bits advance on each falling edge, and 0 is driven once IDX_W bits have gone out.
- R10: While `ctl_sel_n` is high, `spi_miso_en` is 0 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idles low |
| spi_mosi | input | 1 | SPI data in, MSB first |
| ctl_sel_n | input | 1 | Active-low select of the index-loading frame |
| route_sel_n | input | 1 | Active-low select to be routed to one device |
| spi_miso | output | 1 | Echo of the stored index |
| spi_miso_en | output | 1 | Output enable for the MISO driver |
| dev_sel_n | output | NUM_OUT | Active-low device selects |

## Verification
The bench targets frame length. Frames one bit short and one bit long must leave the routing untouched; a design that commits on any select rise would reroute a device. It loads indices 6 and 7, which have no output, and a design that wraps or truncates them would select a live device. It also loads an index while the routed select is held low. An early commit would move the select in mid-transaction, and a lost deferral would keep the old device after release. The MISO echo is sampled bit by bit before each rising edge, which exposes an off-by-one shift or a wrong bit order.

// File: rtl/csx_pkg.sv
package csx_pkg;

    typedef struct packed {
        logic sck;
        logic mosi;
        logic ctl_n;
        logic route_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, ctl_n: 1'b1, route_n: 1'b1};

    typedef enum logic [1:0] {
        EVT_IDLE = 2'd0,
        EVT_LOAD = 2'd1,
        EVT_DROP = 2'd2
    } frame_evt_e;

    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/csx_sync.sv
module csx_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/csx_rx_shifter.sv
module csx_rx_shifter
    import csx_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_s,
    input  logic             mosi_s,
    input  logic             ctl_n_s,
    input  logic [IDX_W-1:0] echo_val,
    output frame_evt_e       evt,
    output logic [IDX_W-1:0] rx_data,
    output logic             miso,
    output logic             miso_en
);
    localparam int CNT_W = $clog2(IDX_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IDX_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(IDX_W + 1);

    logic             sck_q;
    logic             ctl_q;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] shift_q;
    logic [IDX_W-1:0] echo_q;

    logic start, stop, sck_rise, sck_fall;

    assign start    = ctl_q & ~ctl_n_s;
    assign stop     = ~ctl_q & ctl_n_s;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            ctl_q    <= 1'b1;
            active_q <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
            echo_q   <= '0;
        end else begin
            sck_q <= sck_s;
            ctl_q <= ctl_n_s;
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                shift_q  <= '0;
                echo_q   <= echo_val;
            end else if (stop) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                if (sck_rise) begin
                    shift_q <= (shift_q << 1) | IDX_W'(mosi_s);
                    if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                end
                if (sck_fall) begin
                    echo_q <= echo_q << 1;
                end
            end
        end
    end

    always_comb begin
        evt = EVT_IDLE;
        if (stop && active_q) begin
            evt = (cnt_q == CNT_FULL) ? EVT_LOAD : EVT_DROP;
        end
    end

    assign rx_data = shift_q;
    assign miso_en = active_q;
    assign miso    = active_q & echo_q[IDX_W-1];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_OVER); // R4
    AST_ECHO_OFF_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!miso_en && !miso)); // R10
endmodule

// File: rtl/csx_index_store.sv
module csx_index_store
    import csx_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_evt_e       evt,
    input  logic [IDX_W-1:0] rx_data,
    input  logic             route_n_s,
    output logic [IDX_W-1:0] idx,
    output logic             idx_valid
);
    logic [IDX_W-1:0] idx_q;
    logic             valid_q;
    logic [IDX_W-1:0] pend_q;
    logic             pend_v_q;
    logic             busy;

    assign busy = ~route_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            valid_q  <= 1'b0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (evt == EVT_LOAD) begin
            if (busy) begin
                pend_q   <= rx_data;
                pend_v_q <= 1'b1;
            end else begin
                idx_q    <= rx_data;
                valid_q  <= 1'b1;
                pend_v_q <= 1'b0;
            end
        end else if (pend_v_q && !busy) begin
            idx_q    <= pend_q;
            valid_q  <= 1'b1;
            pend_v_q <= 1'b0;
        end
    end

    assign idx       = idx_q;
    assign idx_valid = valid_q;

    AST_IDX_HELD_WHILE_ROUTED: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(idx_q) && $stable(valid_q))); // R7
    AST_DROP_KEEPS_IDX: assert property (@(posedge clk) disable iff (rst)
        (evt == EVT_DROP && !pend_v_q) |=> ($stable(idx_q) && !pend_v_q)); // R4
endmodule

// File: rtl/csx_sel_demux.sv
module csx_sel_demux #(
    parameter int NUM_OUT = 6,
    parameter int IDX_W = 3
) (
    input  logic               route_sel_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               idx_valid,
    output logic [NUM_OUT-1:0] dev_sel_n
);
    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            assign dev_sel_n[i] = route_sel_n | ~idx_valid | (idx != IDX_W'(i));
        end
    endgenerate
endmodule

// File: rtl/csx_expander.sv
module csx_expander
    import csx_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               ctl_sel_n,
    input  logic               route_sel_n,
    output logic               spi_miso,
    output logic               spi_miso_en,
    output logic [NUM_OUT-1:0] dev_sel_n
);
    localparam int IDX_W = idx_bits(NUM_OUT);
    localparam int PIN_W = $bits(pins_t);

    pins_t            pins_raw;
    pins_t            pins_s;
    logic [PIN_W-1:0] pins_s_vec;
    frame_evt_e       evt;
    logic [IDX_W-1:0] rx_data;
    logic [IDX_W-1:0] idx;
    logic             idx_valid;

    assign pins_raw = '{sck: spi_sck, mosi: spi_mosi, ctl_n: ctl_sel_n, route_n: route_sel_n};
    assign pins_s   = pins_t'(pins_s_vec);

    csx_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s_vec)
    );

    csx_rx_shifter #(.IDX_W(IDX_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .sck_s   (pins_s.sck),
        .mosi_s  (pins_s.mosi),
        .ctl_n_s (pins_s.ctl_n),
        .echo_val(idx),
        .evt     (evt),
        .rx_data (rx_data),
        .miso    (spi_miso),
        .miso_en (spi_miso_en)
    );

    csx_index_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rx_data  (rx_data),
        .route_n_s(pins_s.route_n),
        .idx      (idx),
        .idx_valid(idx_valid)
    );

    csx_sel_demux #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_demux (
        .route_sel_n(route_sel_n),
        .idx        (idx),
        .idx_valid  (idx_valid),
        .dev_sel_n  (dev_sel_n)
    );

    AST_AT_MOST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dev_sel_n)); // R3
    AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !idx_valid |-> (&dev_sel_n)); // R2
    AST_RANGE_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (int'(idx) >= NUM_OUT) |-> (&dev_sel_n)); // R5
    AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        route_sel_n |-> (&dev_sel_n)); // R6
endmodule

// File: tb/sim_csx_expander.sv
module sim_csx_expander;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_OUT = 6;
    localparam int HALF = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               spi_sck = 1'b0;
    logic               spi_mosi = 1'b0;
    logic               ctl_sel_n = 1'b1;
    logic               route_sel_n = 1'b1;
    logic               spi_miso;
    logic               spi_miso_en;
    logic [NUM_OUT-1:0] dev_sel_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    csx_expander #(.NUM_OUT(NUM_OUT)) u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .ctl_sel_n(ctl_sel_n), .route_sel_n(route_sel_n),
        .spi_miso(spi_miso), .spi_miso_en(spi_miso_en), .dev_sel_n(dev_sel_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NUM_OUT-1:0] exp_sel(input int idx, input bit low);
        logic [NUM_OUT-1:0] v = '1;
        if (low && idx >= 0 && idx < NUM_OUT) v[idx] = 1'b0;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [NUM_OUT-1:0] act,
                             input logic [NUM_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dev_sel_n actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_bits(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input logic [7:0] val, input int nbits,
                             output logic [7:0] seen, output logic en_all);
        seen = '0;
        en_all = 1'b1;
        ctl_sel_n = 1'b0;
        wait_clks(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_mosi = val[i];
            wait_clks(HALF);
            seen[i] = spi_miso;
            en_all &= spi_miso_en;
            spi_sck = 1'b1;
            wait_clks(HALF);
            spi_sck = 1'b0;
        end
        wait_clks(HALF);
        ctl_sel_n = 1'b1;
        spi_mosi = 1'b0;
        wait_clks(6);
    endtask

    task automatic load(input int v, input int nbits);
        logic [7:0] s;
        logic e;
        spi_frame(8'(v), nbits, s, e);
    endtask

    task automatic probe(input string req, input int idx);
        route_sel_n = 1'b0;
        #1;
        check_vec(req, dev_sel_n, exp_sel(idx, 1'b1));
        route_sel_n = 1'b1;
        #1;
        check_vec(req, dev_sel_n, '1);
        wait_clks(4);
    endtask

    task automatic t_reset;
        check_vec("R1", dev_sel_n, '1);
        check_bits("R1 miso_en/miso", {6'b0, spi_miso_en, spi_miso}, 8'h00);
        probe("R2", -1);
    endtask

    task automatic t_load;
        load(2, 3);
        probe("R3 idx2", 2);
        load(5, 3);
        probe("R3 idx5", 5);
        load(0, 3);
        probe("R6 idx0", 0);
        check_bits("R10 idle miso", {6'b0, spi_miso_en, spi_miso}, 8'h00);
    endtask

    task automatic t_bad_len;
        load(5, 3);
        load(1, 2);
        probe("R4 short", 5);
        load(4'b0011, 4);
        probe("R4 long", 5);
    endtask

    task automatic t_range;
        load(6, 3);
        probe("R5 idx6", -1);
        load(7, 3);
        probe("R5 idx7", -1);
    endtask

    task automatic t_ignore;
        load(2, 3);
        for (int i = 0; i < 5; i++) begin
            spi_mosi = i[0];
            wait_clks(HALF);
            spi_sck = 1'b1;
            wait_clks(HALF);
            spi_sck = 1'b0;
        end
        spi_mosi = 1'b0;
        wait_clks(6);
        probe("R8", 2);
    endtask

    task automatic t_defer;
        load(1, 3);
        route_sel_n = 1'b0;
        wait_clks(4);
        load(3, 3);
        wait_clks(4);
        check_vec("R7 held", dev_sel_n, exp_sel(1, 1'b1));
        route_sel_n = 1'b1;
        wait_clks(5);
        probe("R7 applied", 3);
    endtask

    task automatic t_echo;
        logic [7:0] s;
        logic e;
        spi_frame(8'd4, 3, s, e);
        check_bits("R9 echo bits", {5'b0, s[2:0]}, 8'h03);
        check_bits("R9 miso_en", {7'b0, e}, 8'h01);
        check_bits("R10 after frame", {6'b0, spi_miso_en, spi_miso}, 8'h00);
        probe("R9 new idx", 4);
        spi_frame(8'h0, 4, s, e);
        check_bits("R9 echo tail", {4'b0, s[3:0]}, 8'h08);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clks(4);
        rst = 1'b0;
        wait_clks(4);
        t_reset();
        t_load();
        t_bad_len();
        t_range();
        t_ignore();
        t_defer();
        t_echo();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule